// File: doc/BRIEF.md
# Watchdog Timer with Locked Enable and Two-Key Reload

This block is a supervisory countdown timer for a system-on-chip. Software programs a reload constant, selects whether a fault should request a system reset or raise an interrupt, and then keeps the timer alive by writing two fixed key values to a service register. The timer advances once every four clocks while active. If software stops servicing it, the count runs out and the selected fault action fires. A broken key sequence fires the same fault action.

The block is armed by the first correct key sequence. Until then, the mode bits can be written freely and have no effect. After arming, software can only set mode bits, never clear them. A fault event disarms the block. A hardware reset also disarms it. A sticky status bit records that a reset request was issued. That bit survives the ordinary block reset. Only a power-on reset or a software write of zero clears it.

Top module: `wdog_top`

## Requirements
- R1: After reset the mode register reads 0, the reload register and the count both read 256, the status register reads 0, and `rst_req` and `irq` are low.
- R2: A write to the reload register (address 1) stores the written value. A value below 256 is stored as 256 instead. Reads return the stored value.
- R3: Writing 0xAA to the service register (address 2, bits 7:0), then 0x55 as the very next register access, reloads the count from the reload register and restarts the divide-by-four phase. Idle cycles between the two writes are allowed.
- R4: While active, the count drops by one every four clocks. A read of address 3, taken d clocks after the reload edge, returns N − floor(d/4).
- R5: Before the first valid key sequence, setting mode bit 0 (run) has no effect, and the count holds its value.
- R6: Before arming, the mode register (address 0; bit 0 = run, bit 1 = reset select) takes any written value. After arming, a write can only set bits.
- R7: With the reset select bit at 1, an expiry raises `rst_req` for exactly one clock, 4N clocks after the reload edge, and sets status bit 0 (address 4).
- R8: With the reset select bit at 0, the same expiry raises `irq` for exactly one clock instead, and status bit 0 is left unchanged.
- R9: While active, if any register access follows a 0xAA write other than a 0x55 write to the service register, the fault action fires on that access. While inactive, the same stimulus does nothing.
- R10: A fault event disarms the block. The mode register then reads 0 and the count stops.
- R11: Status bit 0 keeps its value through `rst_n`. Writing 0 to it clears it, writing 1 has no effect, and `por_n` clears it.
- R12: A 0x55 write that does not follow a 0xAA write is ignored. It causes no reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| por_n | input | 1 | Synchronous active-low power-on reset; also clears the status bit |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register select: 0 mode, 1 reload, 2 service, 3 count, 4 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the access |
| rst_req | output | 1 | One-clock system reset request |
| irq | output | 1 | One-clock interrupt pulse |

## Verification
Register writes take effect at the clock edge of the access, and reads are combinational, so every readback is sampled a nanosecond after the falling edge that presents the access. The bench counts clock edges from the write edge of the 0x55 key. It expects count N − floor(d/4) at edge distance d, and a fault pulse exactly 4N edges later. A key-sequence fault lands on the edge of the offending access. The pulse monitor runs on falling edges, and the counts are compared only two idle cycles after that access, which keeps them clear of the edge at which the monitor updates.

// File: rtl/wdog_pkg.sv
// Shared definitions for the watchdog: register map, service keys, mode bits.
package wdog_pkg;

    typedef enum logic [2:0] {
        WD_MODE   = 3'd0,
        WD_RELOAD = 3'd1,
        WD_FEED   = 3'd2,
        WD_COUNT  = 3'd3,
        WD_STATUS = 3'd4
    } wd_reg_e;

    localparam logic [7:0] WD_KEY_FIRST  = 8'hAA;
    localparam logic [7:0] WD_KEY_SECOND = 8'h55;

    typedef struct packed {
        logic rst_sel;   // 1: fault requests reset, 0: fault raises interrupt
        logic run_en;    // 1: countdown runs once armed
    } wd_mode_t;

endpackage

// File: rtl/wdog_feed_seq.sv
// Two-key service sequence detector.
// Watches every register access. A write of the first key arms a pending
// flag; the next access completes the sequence when it writes the second
// key to the service register, otherwise it is reported as a broken
// sequence. Idle cycles do not disturb the pending flag.
// Assumes one access per cycle, qualified by acc.
module wdog_feed_seq
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc,
    input  logic       wr,
    input  logic       to_feed,
    input  logic [7:0] key,
    output logic       feed_ok,
    output logic       feed_bad
);

    logic pend_q;
    logic key1_wr;
    logic key2_wr;

    // Classify the current access against the two keys.
    always_comb begin
        key1_wr  = acc && wr && to_feed && (key == WD_KEY_FIRST);
        key2_wr  = acc && wr && to_feed && (key == WD_KEY_SECOND);
        feed_ok  = pend_q && key2_wr;
        feed_bad = pend_q && acc && !key2_wr;
    end

    // Track whether the first key is waiting for its partner.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (acc)
            pend_q <= key1_wr && !pend_q;
    end

    // R9: any access that follows a pending first key ends the sequence
    // R9
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && acc) |=> !pend_q);

    // R12: a lone second key never leaves a sequence pending
    // R12
    lone_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q && key2_wr) |=> !pend_q);

endmodule

// File: rtl/wdog_count.sv
// Prescaled down-counter.
// A fixed prescaler divides the clock by PRESC. Each prescaler wrap
// decrements the count while run is high. A reload loads the count and
// restarts the prescaler phase, and it takes priority over counting.
// expire flags the tick that takes the count from 1 to 0.
module wdog_count #(
    parameter int CNT_W      = 32,
    parameter int PRESC      = 4,
    parameter int MIN_RELOAD = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             reload,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);

    localparam int PS_W = (PRESC > 1) ? $clog2(PRESC) : 1;
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESC - 1);

    logic [PS_W-1:0] ps_q;
    logic            tick;

    // Prescaler wrap and expiry detection.
    always_comb begin
        tick   = run && (ps_q == PS_LAST);
        expire = tick && (cnt_q == CNT_W'(1));
    end

    // Prescaler phase: restart on reload, advance while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ps_q <= '0;
        else if (reload)
            ps_q <= '0;
        else if (run)
            ps_q <= (ps_q == PS_LAST) ? '0 : ps_q + 1'b1;
    end

    // Count value: load on reload, step down on each prescaler tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= CNT_W'(MIN_RELOAD);
        else if (reload)
            cnt_q <= load_val;
        else if (tick)
            cnt_q <= cnt_q - 1'b1;
    end

    // R3: reload loads the constant and restarts the phase
    // R3
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt_q == $past(load_val)) && (ps_q == '0));

    // R4: the count only moves on a prescaler wrap
    // R4
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && !(run && ps_q == PS_LAST)) |=> $stable(cnt_q));

endmodule

// File: rtl/wdog_regs.sv
// Software-visible state of the watchdog: mode bits, arm state, reload
// constant and the sticky reset-cause bit.
// Mode bits are freely writable until the first valid service sequence;
// afterwards writes can only set bits. A fault clears mode and arm state.
// The cause bit is reset only by por_n, never by rst_n.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int MIN_RELOAD = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic             wr_mode,
    input  logic             wr_reload,
    input  logic             wr_status,
    input  logic [CNT_W-1:0] wdata,
    input  logic             feed_ok,
    input  logic             fault,
    output wd_mode_t         mode_q,
    output logic             armed_q,
    output logic [CNT_W-1:0] reload_q,
    output logic             flag_q
);

    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_RELOAD);

    wd_mode_t wr_bits;

    // Mode bits carried by the write data.
    always_comb wr_bits = wd_mode_t'(wdata[1:0]);

    // Mode register: free before arming, set-only after, cleared by a fault.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (fault)
            mode_q <= '0;
        else if (wr_mode)
            mode_q <= armed_q ? (mode_q | wr_bits) : wr_bits;
    end

    // Arm state: set by the first valid sequence, dropped by a fault.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (fault)
            armed_q <= 1'b0;
        else if (feed_ok)
            armed_q <= 1'b1;
    end

    // Reload constant with a lower floor.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reload_q <= FLOOR;
        else if (wr_reload)
            reload_q <= (wdata < FLOOR) ? FLOOR : wdata;
    end

    // Sticky reset-cause bit: set by a reset-type fault, cleared by writing 0.
    always_ff @(posedge clk) begin
        if (!por_n)
            flag_q <= 1'b0;
        else if (fault && mode_q.rst_sel)
            flag_q <= 1'b1;
        else if (wr_status && !wdata[0])
            flag_q <= 1'b0;
    end

    // R2: the stored constant never drops below the floor
    // R2
    floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_q >= FLOOR);

    // R6: once armed, mode bits only clear through a fault
    // R6
    set_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !fault) |=> ((mode_q & $past(mode_q)) == $past(mode_q)));

endmodule

// File: rtl/wdog_top.sv
// Watchdog timer top level.
// Decodes a simple single-cycle register bus, combines the service-key
// detector, the prescaled counter and the register state, and turns a
// timeout or a broken key sequence into a one-clock reset request or
// interrupt. Assumes that all inputs are synchronous to clk and that the
// reset generator outside the block acts on rst_req.
module wdog_top
    import wdog_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int PRESC      = 4,
    parameter int MIN_RELOAD = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             rst_req,
    output logic             irq
);

    logic             wr_en;
    logic             wr_mode;
    logic             wr_reload;
    logic             wr_status;
    logic             to_feed;
    logic             feed_ok;
    logic             feed_bad;
    logic             expire;
    logic             active;
    logic             fault;
    wd_mode_t         mode_q;
    logic             armed_q;
    logic             flag_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_q;

    // Write strobes per register.
    always_comb begin
        wr_en     = bus_sel && bus_wr;
        wr_mode   = wr_en && (bus_addr == WD_MODE);
        wr_reload = wr_en && (bus_addr == WD_RELOAD);
        wr_status = wr_en && (bus_addr == WD_STATUS);
        to_feed   = (bus_addr == WD_FEED);
    end

    wdog_feed_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (bus_sel),
        .wr       (bus_wr),
        .to_feed  (to_feed),
        .key      (bus_wdata[7:0]),
        .feed_ok  (feed_ok),
        .feed_bad (feed_bad)
    );

    wdog_regs #(
        .CNT_W      (CNT_W),
        .MIN_RELOAD (MIN_RELOAD)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_n     (por_n),
        .wr_mode   (wr_mode),
        .wr_reload (wr_reload),
        .wr_status (wr_status),
        .wdata     (bus_wdata),
        .feed_ok   (feed_ok),
        .fault     (fault),
        .mode_q    (mode_q),
        .armed_q   (armed_q),
        .reload_q  (reload_q),
        .flag_q    (flag_q)
    );

    wdog_count #(
        .CNT_W      (CNT_W),
        .PRESC      (PRESC),
        .MIN_RELOAD (MIN_RELOAD)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (active),
        .reload   (feed_ok),
        .load_val (reload_q),
        .cnt_q    (cnt_q),
        .expire   (expire)
    );

    // Fault decision: expiry not rescued by a same-cycle reload, or a broken sequence.
    always_comb begin
        active = armed_q && mode_q.run_en;
        fault  = active && ((expire && !feed_ok) || feed_bad);
    end

    // One-clock fault pulses, routed by the reset-select bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
            irq     <= 1'b0;
        end else begin
            rst_req <= fault && mode_q.rst_sel;
            irq     <= fault && !mode_q.rst_sel;
        end
    end

    // Combinational register readback.
    always_comb begin
        case (bus_addr)
            WD_MODE:   bus_rdata = CNT_W'({mode_q.rst_sel, mode_q.run_en});
            WD_RELOAD: bus_rdata = reload_q;
            WD_COUNT:  bus_rdata = cnt_q;
            WD_STATUS: bus_rdata = CNT_W'(flag_q);
            default:   bus_rdata = '0;
        endcase
    end

    // R7: a reset request lasts exactly one clock
    // R7
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R7: a reset request is always recorded in the cause bit
    // R7
    rst_flag_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        rst_req |-> flag_q);

    // R8: an interrupt lasts exactly one clock
    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R10: the block is inactive right after any fault pulse
    // R10
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || irq) |-> (!active && mode_q == '0));

    // R5: the count holds until armed, except for a reload
    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !feed_ok) |=> $stable(cnt_q));

    // R11: the cause bit only rises together with a reset request
    // R11
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (flag_q && !$past(flag_q)) |-> rst_req);

endmodule

// File: tb/sim_wdog_top.sv
module sim_wdog_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        rst_req;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rst_cnt = 0;
    int irq_cnt = 0;
    int rst_cyc = -1;
    int irq_cyc = -1;
    int last_wr_cyc = 0;
    int rd_cyc = 0;

    always #10 clk = ~clk;

    wdog_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_n     (por_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rst_req   (rst_req),
        .irq       (irq)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Fault pulse monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_req) begin
            rst_cnt = rst_cnt + 1;
            rst_cyc = cyc;
        end
        if (irq) begin
            irq_cnt = irq_cnt + 1;
            irq_cyc = cyc;
        end
    end

    function automatic logic [31:0] exp_reload(input logic [31:0] v);
        return (v < 32'd256) ? 32'd256 : v;
    endfunction

    function automatic logic [31:0] exp_count(input logic [31:0] n, input int d);
        return n - 32'(d / 4);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        last_wr_cyc = cyc;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        rd_cyc = cyc;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic feed();
        wr(3'd2, 32'hAA);
        wr(3'd2, 32'h55);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        errors = errors + 1;
        $display("FAIL watchdog run timed out");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] v2;
        int f;
        int rb;
        int ib;
        void'($urandom(32'd2718));

        idle(5);
        rst_n = 1'b1; por_n = 1'b1;
        idle(1);

        // R1 reset state
        check("R1 rst_req", 32'(rst_req), 0);
        check("R1 irq", 32'(irq), 0);
        rd(3'd0, v); check("R1 mode", v, 0);
        rd(3'd1, v); check("R1 reload", v, 256);
        rd(3'd3, v); check("R1 count", v, 256);
        rd(3'd4, v); check("R1 status", v, 0);

        // R2 directed and random constants
        wr(3'd1, 32'd0);          rd(3'd1, v); check("R2 zero", v, 256);
        wr(3'd1, 32'd255);        rd(3'd1, v); check("R2 255", v, 256);
        wr(3'd1, 32'd256);        rd(3'd1, v); check("R2 256", v, 256);
        wr(3'd1, 32'hFFFF_FFFF);  rd(3'd1, v); check("R2 max", v, 32'hFFFF_FFFF);
        for (int i = 0; i < 8; i++) begin
            logic [31:0] r;
            r = 32'($urandom_range(0, 600));
            wr(3'd1, r); rd(3'd1, v); check("R2 random", v, exp_reload(r));
        end

        // R6 free writes before arming; R5 no counting before arming
        wr(3'd1, 32'd300);
        wr(3'd0, 32'd3); rd(3'd0, v); check("R6 prearm set", v, 3);
        wr(3'd0, 32'd0); rd(3'd0, v); check("R6 prearm clear", v, 0);
        wr(3'd0, 32'd1);
        idle(40);
        rd(3'd3, v); check("R5 count held", v, 256);
        check("R5 no irq", 32'(irq_cnt), 0);

        // R12 lone second key
        wr(3'd2, 32'h55);
        rd(3'd3, v); check("R12 no reload", v, 256);

        // R3 valid sequence reloads
        feed(); f = last_wr_cyc;
        rd(3'd3, v); check("R3 reload", v, exp_count(300, rd_cyc - f));

        // R6 set-only after arming
        wr(3'd0, 32'd0); rd(3'd0, v); check("R6 no clear", v, 1);

        // R4 random sampling of the countdown
        for (int i = 0; i < 6; i++) begin
            idle($urandom_range(0, 50));
            rd(3'd3, v); check("R4 countdown", v, exp_count(300, rd_cyc - f));
        end

        // R8 expiry with interrupt selected
        feed(); f = last_wr_cyc;
        ib = irq_cnt; rb = rst_cnt;
        wait_until(f + 1200 + 3);
        check("R8 irq count", 32'(irq_cnt), 32'(ib + 1));
        check("R8 irq cycle", 32'(irq_cyc), 32'(f + 1200));
        check("R8 no reset", 32'(rst_cnt), 32'(rb));
        rd(3'd4, v); check("R8 status", v, 0);

        // R10 disarmed after fault
        rd(3'd0, v); check("R10 mode", v, 0);
        rd(3'd3, v);
        idle(20);
        rd(3'd3, v2);
        check("R10 count zero", v, 0);
        check("R10 count stopped", v2, v);

        // R9 broken sequence while active, reset selected
        wr(3'd1, 32'd256);
        wr(3'd0, 32'd3);
        feed();
        wr(3'd0, 32'd1); rd(3'd0, v); check("R6 keeps bits", v, 3);
        rb = rst_cnt;
        wr(3'd2, 32'hAA);
        rd(3'd1, v);
        idle(2);
        check("R9 bad seq reset", 32'(rst_cnt), 32'(rb + 1));
        rd(3'd4, v); check("R7 flag set", v, 1);
        rd(3'd0, v); check("R10 mode after reset", v, 0);

        // R11 flag survives block reset
        @(negedge clk); rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        rd(3'd4, v); check("R11 survive rst_n", v, 1);

        // R9 broken sequence while inactive is harmless
        rb = rst_cnt; ib = irq_cnt;
        wr(3'd2, 32'hAA);
        rd(3'd1, v);
        idle(2);
        check("R9 inactive rst", 32'(rst_cnt), 32'(rb));
        check("R9 inactive irq", 32'(irq_cnt), 32'(ib));

        // R7 expiry with reset selected
        wr(3'd0, 32'd3);
        rb = rst_cnt;
        feed(); f = last_wr_cyc;
        wait_until(f + 1024 + 3);
        check("R7 reset count", 32'(rst_cnt), 32'(rb + 1));
        check("R7 reset cycle", 32'(rst_cyc), 32'(f + 1024));

        // R11 software clear
        wr(3'd4, 32'd1); rd(3'd4, v); check("R11 write one", v, 1);
        wr(3'd4, 32'd0); rd(3'd4, v); check("R11 write zero", v, 0);

        // R9 doubled first key, then R11 power-on clear
        wr(3'd0, 32'd3);
        feed();
        rb = rst_cnt;
        wr(3'd2, 32'hAA);
        wr(3'd2, 32'hAA);
        idle(2);
        check("R9 double key", 32'(rst_cnt), 32'(rb + 1));
        rd(3'd4, v); check("R11 set again", v, 1);
        @(negedge clk); rst_n = 1'b0; por_n = 1'b0;
        idle(3);
        rst_n = 1'b1; por_n = 1'b1;
        rd(3'd4, v); check("R11 por clear", v, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule